// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is the watchdog of a small microcontroller core. A base tick comes either from a pulse input that stands in for a dedicated low-speed oscillator, or from the system clock divided by four. A static configuration input chooses between them. A 7-bit prescaler counts base ticks, and three bits of a byte-wide status register pick one of eight prescaler taps. The picked tap advances an 8-bit time-out counter. When that counter overflows, the block raises a one-cycle time-out pulse and sets a sticky time-out flag.

Firmware keeps the watchdog from expiring with clear strobes. A second static input picks the clear discipline. In single mode, one general clear strobe restarts the timer. In dual mode, two separate strobes must both be seen before the restart happens. Entering the halt state always restarts the timer and drops the flag. The asynchronous reset returns everything to zero. The five upper bits of the status register are free flags for firmware. They are stored and read back but have no effect on timing.

Top module: `wdog_timer`

## Requirements
- R1: While rst_ni is low, the status register, counter, prescaler, divider and clear latches are zero, and timeout_o and to_flag_o are low.
- R2: A cycle with reg_we_i high loads reg_wdata_i into the status register, and reg_rdata_o shows the stored byte from the next cycle on. Bits 7..3 are free flags and do not change timing.
- R3: Status bits 2..0 hold a value k that sets the prescaler ratio to 1:2^k. After a clear, the first time-out comes 256*2^k base ticks later. timeout_o is high in the cycle that follows the clock edge of the final tick.
- R4: timeout_o is a single-cycle pulse. The same edge sets to_flag_o, and the flag stays set. The counter wraps to zero, so with no clear the next pulse follows one full period later.
- R5: In single mode (dual_clr_i=0), a clr_i strobe clears the counter, prescaler and divider. clr_a_i and clr_b_i are ignored.
- R6: In dual mode (dual_clr_i=1), clr_i is ignored. Two latches record clr_a_i and clr_b_i, in either order or together, and the clear occurs in the cycle in which both are seen. Both latches then reset. Repeating one strobe has no further effect, and a latch keeps its state until the clear happens.
- R7: A halt_entry_i strobe clears the counter, prescaler, divider and both latches, and also clears to_flag_o.
- R8: With src_osc_i=0, the base tick is one system clock cycle in four, counted from the last clear. While halt_i is high the divider, prescaler and counter hold, so a halt lasting H cycles delays the time-out by exactly H cycles.
- R9: With src_osc_i=1, each cycle with osc_en_i high is one base tick, and counting goes on while halt_i is high.
- R10: A clear in the same cycle as a tick takes priority, and the counter is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| src_osc_i | input | 1 | Static: 1 = oscillator enable tick, 0 = system clock / 4 |
| dual_clr_i | input | 1 | Static: 1 = two-strobe clear discipline |
| osc_en_i | input | 1 | One-cycle enable pulse from the watchdog oscillator |
| halt_i | input | 1 | Core is in the halt state |
| halt_entry_i | input | 1 | Strobe on execution of the halt instruction |
| clr_i | input | 1 | Single-mode clear strobe |
| clr_a_i | input | 1 | First dual-mode clear strobe |
| clr_b_i | input | 1 | Second dual-mode clear strobe |
| reg_we_i | input | 1 | Status register write enable |
| reg_wdata_i | input | 8 | Status register write data |
| reg_rdata_o | output | 8 | Status register read data |
| timeout_o | output | 1 | One-cycle time-out pulse |
| to_flag_o | output | 1 | Sticky time-out flag |

## Verification
The bench predicts the exact cycle of every time-out pulse. A tap that is off by one stage would therefore show up as a pulse at half or double the period, and a clear that was not honoured, or was applied wrongly, would show up as a pulse at the wrong cycle or one that nobody expected. In dual mode it tests a lone clr_i, a repeated lone strobe after the latches reset, and a latch set early that must survive until its partner arrives. A design that cleared on any strobe would move the pulse. In the halt test with the system-clock source, a divider that kept running would produce the pulse 100 cycles early. The bench also writes free flag bits next to a nonzero select value, which catches select decoding that takes in the upper bits.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int WDOG_PRE_W = 7;
  localparam int WDOG_CNT_W = 8;
  localparam int WDOG_REG_W = 8;
  localparam int WDOG_DIV_W = 2;
  localparam int WDOG_SEL_W = $clog2(WDOG_PRE_W + 1);

  typedef enum logic {
    CLR_SINGLE = 1'b0,
    CLR_DUAL   = 1'b1
  } clr_mode_e;

  typedef struct packed {
    logic entry;
    logic gen;
    logic a;
    logic b;
  } clr_req_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic src_osc_i,
  input  logic osc_en_i,
  input  logic halt_i,
  output logic tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             sys_run;

  // system clock path freezes while the core is halted
  assign sys_run = !halt_i && !src_osc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (sys_run) div_q <= div_q + 1'b1;
  end

  always_comb begin
    if (clr_i)          tick_o = 1'b0;
    else if (src_osc_i) tick_o = osc_en_i;
    else                tick_o = sys_run && (&div_q);
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o
);
  localparam int N_TAPS = PRE_W + 1;

  logic [PRE_W-1:0]  pre_q;
  logic [N_TAPS-1:0] taps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end

  // tap k fires when the low k prescaler bits roll over
  assign taps[0] = tick_i;
  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    assign taps[k] = tick_i && (&pre_q[k-1:0]);
  end

  assign tap_o = !clr_i && taps[sel_i];
endmodule

// File: rtl/wdog_clr_ctl.sv
module wdog_clr_ctl
  import wdog_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  clr_mode_e mode_i,
  input  clr_req_t  req_i,
  output logic      clr_o
);
  logic seen_a_q, seen_b_q;
  logic pair_done;

  assign pair_done = (seen_a_q || req_i.a) && (seen_b_q || req_i.b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (req_i.entry || pair_done || mode_i == CLR_SINGLE) begin
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else begin
      seen_a_q <= seen_a_q || req_i.a;
      seen_b_q <= seen_b_q || req_i.b;
    end
  end

  always_comb begin
    unique case (mode_i)
      CLR_SINGLE: clr_o = req_i.entry || req_i.gen;
      CLR_DUAL:   clr_o = req_i.entry || pair_done;
      default:    clr_o = req_i.entry;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int PRE_W = WDOG_PRE_W,
  parameter int CNT_W = WDOG_CNT_W,
  parameter int REG_W = WDOG_REG_W,
  parameter int DIV_W = WDOG_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_osc_i,
  input  logic             dual_clr_i,
  input  logic             osc_en_i,
  input  logic             halt_i,
  input  logic             halt_entry_i,
  input  logic             clr_i,
  input  logic             clr_a_i,
  input  logic             clr_b_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             timeout_o,
  output logic             to_flag_o
);
  localparam int SEL_W = $clog2(PRE_W + 1);

  logic [REG_W-1:0] stat_q;
  logic             wdt_clr;
  logic             base_tick;
  logic             tap;
  logic             wrap;
  logic [CNT_W-1:0] wdt_cnt;
  logic             timeout_q, to_q;
  clr_req_t         req;
  clr_mode_e        mode;

  assign req  = '{entry: halt_entry_i, gen: clr_i, a: clr_a_i, b: clr_b_i};
  assign mode = dual_clr_i ? CLR_DUAL : CLR_SINGLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= '0;
    else if (reg_we_i) stat_q <= reg_wdata_i;
  end

  wdog_clr_ctl u_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .req_i  (req),
    .clr_o  (wdt_clr)
  );

  wdog_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (wdt_clr),
    .src_osc_i (src_osc_i),
    .osc_en_i  (osc_en_i),
    .halt_i    (halt_i),
    .tick_o    (base_tick)
  );

  wdog_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wdt_clr),
    .tick_i (base_tick),
    .sel_i  (stat_q[SEL_W-1:0]),
    .tap_o  (tap)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wdt_clr),
    .inc_i  (tap),
    .cnt_o  (wdt_cnt),
    .wrap_o (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      timeout_q <= wrap;
      if (halt_entry_i) to_q <= 1'b0;
      else if (wrap)    to_q <= 1'b1;
    end
  end

  assign reg_rdata_o = stat_q;
  assign timeout_o   = timeout_q;
  assign to_flag_o   = to_q;
endmodule

module wdog_timer_chk #(
  parameter int CNT_W = 8,
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             src_osc_i,
  input logic             dual_clr_i,
  input logic             halt_i,
  input logic             halt_entry_i,
  input logic             clr_i,
  input logic             clr_a_i,
  input logic             clr_b_i,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             timeout_o,
  input logic             to_flag_o,
  input logic [CNT_W-1:0] wdt_cnt,
  input logic             wdt_clr
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (wdt_cnt == '0 && !timeout_o && !to_flag_o && reg_rdata_o == '0)
        else $error("reset state not held");
    end
  end

  // R2
  reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == $past(reg_wdata_i));

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  // R4
  flag_with_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> to_flag_o);

  // R5
  single_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_clr_i && clr_i) |-> wdt_clr);

  // R6
  dual_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_clr_i && clr_i && !clr_a_i && !clr_b_i && !halt_entry_i) |-> !wdt_clr);

  // R7
  halt_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_entry_i |=> !to_flag_o && !timeout_o && wdt_cnt == '0);

  // R8
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_osc_i && halt_i && !wdt_clr) |=> $stable(wdt_cnt) && !timeout_o);

  // R10
  clr_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr |=> wdt_cnt == '0 && !timeout_o);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_osc_i    (src_osc_i),
  .dual_clr_i   (dual_clr_i),
  .halt_i       (halt_i),
  .halt_entry_i (halt_entry_i),
  .clr_i        (clr_i),
  .clr_a_i      (clr_a_i),
  .clr_b_i      (clr_b_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .timeout_o    (timeout_o),
  .to_flag_o    (to_flag_o),
  .wdt_cnt      (wdt_cnt),
  .wdt_clr      (wdt_clr)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam int PERIOD     = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src_osc = 1'b1, dual = 1'b0, osc_en = 1'b1, halt = 1'b0;
  logic       halt_entry = 1'b0, clr = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       timeout, to_flag;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .src_osc_i(src_osc), .dual_clr_i(dual),
    .osc_en_i(osc_en), .halt_i(halt), .halt_entry_i(halt_entry),
    .clr_i(clr), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .timeout_o(timeout), .to_flag_o(to_flag)
  );

  task automatic fail(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, act, exp);
  endtask

  task automatic expect_pulse(input int at, input string req);
    exp_q.push_back(at);
    req_q.push_back(req);
  endtask

  // monitor: every pulse must match the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && timeout) begin
      checks++;
      if (exp_q.size() == 0) fail("unexpected pulse", cyc, -1);
      else begin
        int    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (cyc != e) fail(r, cyc, e);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
    check("R2 readback", rdata, d);
  endtask

  // m = {halt_entry, clr, clr_a, clr_b}; c = cycle of the sampling edge
  task automatic strobe(input logic [3:0] m, output int c);
    @(negedge clk);
    {halt_entry, clr, clr_a, clr_b} = m;
    @(negedge clk);
    {halt_entry, clr, clr_a, clr_b} = 4'b0000;
    c = cyc;
  endtask

  initial begin
    int c, e, f;
    wait_cyc(3);
    check("R1 timeout", timeout, 0);
    check("R1 flag", to_flag, 0);
    check("R1 reg", rdata, 0);
    rst_n = 1'b1;

    // R3 ratio 1:1, R10 clear wins over tick, R4 periodic wrap
    write_reg(8'h00);
    strobe(4'b0100, c);
    expect_pulse(c + PERIOD, "R3 k=0");
    expect_pulse(c + 2*PERIOD, "R4 wrap period");
    wait_cyc(260);
    check("R4 flag set", to_flag, 1);
    wait_cyc(260);

    // R5 single mode ignores clr_a/clr_b
    strobe(4'b0100, c);
    wait_cyc(100);
    strobe(4'b0011, f);
    expect_pulse(c + PERIOD, "R5 pair ignored");
    wait_cyc(170);

    // R5 a clear restarts the period
    strobe(4'b0100, c);
    wait_cyc(200);
    strobe(4'b0100, c);
    expect_pulse(c + PERIOD, "R5 restart");
    wait_cyc(270);

    // R3 ratio 1:4
    write_reg(8'h02);
    strobe(4'b0100, c);
    expect_pulse(c + 4*PERIOD, "R3 k=2");
    wait_cyc(1030);

    // R2 free flags leave the select alone (sel=1)
    write_reg(8'hA9);
    strobe(4'b0100, c);
    expect_pulse(c + 2*PERIOD, "R2 flags k=1");
    wait_cyc(520);
    write_reg(8'h00);

    // R6 dual mode
    dual = 1'b1;
    strobe(4'b0011, c);
    wait_cyc(90);
    strobe(4'b0100, f);
    expect_pulse(c + PERIOD, "R6 clr_i ignored");
    wait_cyc(170);
    strobe(4'b0010, f);
    wait_cyc(50);
    strobe(4'b0010, f);
    wait_cyc(50);
    strobe(4'b0001, e);
    expect_pulse(e + PERIOD, "R6 pair clear");
    wait_cyc(50);
    strobe(4'b0001, f);
    wait_cyc(30);
    strobe(4'b0001, f);
    wait_cyc(200);
    strobe(4'b0010, f);
    expect_pulse(f + PERIOD, "R6 latch kept");
    wait_cyc(260);
    dual = 1'b0;

    // R7 halt entry clears flag and restarts
    strobe(4'b1000, c);
    check("R7 flag cleared", to_flag, 0);
    expect_pulse(c + PERIOD, "R7 restart");
    wait_cyc(260);
    check("R7 flag set again", to_flag, 1);

    // R9 oscillator source keeps counting in halt
    halt = 1'b1;
    strobe(4'b0100, c);
    expect_pulse(c + PERIOD, "R9 osc in halt");
    wait_cyc(260);
    halt = 1'b0;

    // R8 system clock / 4
    src_osc = 1'b0;
    strobe(4'b0100, c);
    expect_pulse(c + 4*PERIOD, "R8 div4");
    wait_cyc(1030);
    strobe(4'b0100, c);
    wait_cyc(300);
    halt = 1'b1;
    wait_cyc(100);
    halt = 1'b0;
    expect_pulse(c + 4*PERIOD + 100, "R8 halt freeze");
    wait_cyc(740);

    check("R4 no pulse missing", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    checks++;
    fail("watchdog expired", cyc, WD_LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule